// File: doc/BRIEF.md
# Conference Bridge Host Command Port

This block is the host side of a voice-conferencing engine. A host processor talks to it over an 8-bit asynchronous bus with active-low chip select, read and write strobes, and a control/data select line. The host sends an instruction as zero to two data bytes (select low) followed by one opcode byte (select high). The opcode byte commits the buffered bytes to a per-channel table, or to the PCM mode registers. The mixing datapath reads the table through a lookup port and returns one overflow flag per conference.

The strobes are brought into the core clock through a synchroniser chain. While the synchronised write strobe is low, the block holds the byte, the select line and the chip select. On its rising edge the block acts on that byte. Reads are combinational from the pins. They return either the live overflow flags or, after a status instruction, a status byte for one channel. Status mode stays active until the next data write.

Top module: `conf_host_port`

## Requirements
- R1: A byte is accepted on the rising edge of the write strobe only while chip select is low. Select low means data byte and select high means opcode byte. The opcode is bits 3:0. A write with chip select high has no effect.
- R2: Opcode 0111 (conference connect) uses two data bytes. The older byte holds start in bit 4 and conference 3:0; the newer holds tone in bit 5 and channel in 4:0. The opcode byte holds attenuation 7:6 and threshold 5:4. The entry gets mode = conference. A conference number outside 1..10 changes nothing.
- R3: Opcode 0011 (transparent) uses one data byte, channel in 4:0. The entry gets mode 1111, attenuation and threshold from the opcode byte, and tone and start both 0.
- R4: Opcode 1111 (disconnect) uses one data byte, the channel. The entry is cleared to mode 0000 with all other fields 0.
- R5: Opcode 0101 (mode select) sets the extra-bit flag from bit 6 and the format from bits 5:4. Until the first mode select after reset, the format is 01 with law_a high and 11 with law_a low, and the extra-bit flag is 0.
- R6: An opcode with too few buffered data bytes, or an opcode not listed here, changes nothing. Every opcode empties the data buffer.
- R7: With chip select and read low, the bus returns overflow flags for conferences 8..1 on bits 7:0 when select is low. When select is high it returns conferences 10 and 9 on bits 1:0, with the upper bits 0. The value follows the flags live.
- R8: Opcode 0110 (status) uses one data byte, the channel. Reads then return {mode, attenuation, threshold} of that channel on bits 7:4, 3:2 and 1:0 until a data write with chip select low, after which reads return overflow again.
- R9: The bus is not driven while chip select is high or reset is active.
- R10: After reset every table entry has mode 0000 and all other fields 0.
- R11: When more data bytes arrive than an instruction needs, the most recent ones are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_a | input | 1 | 1 = A-law, 0 = µ-law; picks the format default |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_cd | input | 1 | 0 = data byte, 1 = opcode byte; picks the overflow half on reads |
| bus_in | input | 8 | Bus value driven by the host |
| bus_out | output | 8 | Bus value driven by the block |
| bus_oe | output | 1 | Bus drive enable |
| ovf_flags | input | NCONF | Overflow flag per conference, bit 0 = conference 1 |
| tbl_sel | input | 5 | Channel looked up by the datapath |
| tbl_mode | output | 4 | Mode of the selected channel: 0 none, 1..10 conference, 15 transparent |
| tbl_att | output | 2 | Attenuation code |
| tbl_thr | output | 2 | Noise threshold code |
| tbl_tone | output | 1 | Tone insertion enable |
| tbl_start | output | 1 | Conference start flag |
| fmt_bits | output | 2 | PCM byte format |
| extra_bit | output | 1 | Extra framing bit flag |

## Verification
A wrong buffer count or a stale byte in the buffer shows up as a table entry written with the wrong fields, or not written at all. The lookup port shows this about three clocks after the opcode strobe rises, and the lookup sweep reaches that channel within 32 cycles. A status flag stuck high or low shows up on the very next read as a status byte in place of overflow flags, or the reverse. A fault in the format default shows up on fmt_bits in the first cycle after reset.

// File: rtl/conf_port_pkg.sv
package conf_port_pkg;
  typedef struct packed {
    logic [3:0] mode;
    logic [1:0] att;
    logic [1:0] thr;
    logic       tone;
    logic       start;
  } chan_entry_t;

  localparam logic [3:0] OP_CONNECT = 4'b0111;
  localparam logic [3:0] OP_TRANSP  = 4'b0011;
  localparam logic [3:0] OP_DISCON  = 4'b1111;
  localparam logic [3:0] OP_MODESEL = 4'b0101;
  localparam logic [3:0] OP_STATUS  = 4'b0110;

  localparam logic [3:0] MODE_NONE   = 4'b0000;
  localparam logic [3:0] MODE_TRANSP = 4'b1111;
endpackage

// File: rtl/conf_strobe_sync.sv
module conf_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_n,
  input  logic       cs_n,
  input  logic       cd,
  input  logic [7:0] din,
  output logic       evt,
  output logic       evt_cd,
  output logic [7:0] evt_data
);
  logic [STAGES-1:0] chain;
  logic              wr_s, wr_q;
  logic [7:0]        cap_data, cap_data_n;
  logic              cap_cd, cap_cd_n, cap_sel, cap_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= wr_n;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign wr_s = chain[STAGES-1];

  always_comb begin
    cap_data_n = cap_data;
    cap_cd_n   = cap_cd;
    cap_sel_n  = cap_sel;
    if (!wr_s) begin
      cap_data_n = din;
      cap_cd_n   = cd;
      cap_sel_n  = ~cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      cap_data <= '0;
      cap_cd   <= 1'b0;
      cap_sel  <= 1'b0;
    end else begin
      wr_q     <= wr_s;
      cap_data <= cap_data_n;
      cap_cd   <= cap_cd_n;
      cap_sel  <= cap_sel_n;
    end
  end

  assign evt      = wr_s & ~wr_q & cap_sel;
  assign evt_cd   = cap_cd;
  assign evt_data = cap_data;
endmodule

// File: rtl/conf_cmd_decoder.sv
module conf_cmd_decoder
  import conf_port_pkg::*;
#(
  parameter int NCHAN = 32,
  parameter int NCONF = 10,
  localparam int CHW  = $clog2(NCHAN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt,
  input  logic            evt_cd,
  input  logic [7:0]      evt_data,
  output logic            tbl_we,
  output logic [CHW-1:0]  tbl_wchan,
  output chan_entry_t     tbl_wentry,
  output logic            mode_we,
  output logic            mode_extra,
  output logic [1:0]      mode_fmt,
  output logic            stat_set,
  output logic            stat_clr,
  output logic [CHW-1:0]  stat_chan
);
  logic [7:0] byte_old, byte_old_n, byte_new, byte_new_n;
  logic [1:0] cnt, cnt_n;
  logic [3:0] op;
  logic       conf_ok;
  logic       unused_bits;

  assign op      = evt_data[3:0];
  assign conf_ok = (byte_old[3:0] != 4'd0) && (byte_old[3:0] <= 4'(NCONF));
  assign unused_bits = ^{byte_old[7:5], byte_new[7:6]};

  always_comb begin
    byte_old_n = byte_old;
    byte_new_n = byte_new;
    cnt_n      = cnt;
    tbl_we     = 1'b0;
    tbl_wchan  = byte_new[CHW-1:0];
    tbl_wentry = '0;
    mode_we    = 1'b0;
    mode_extra = evt_data[6];
    mode_fmt   = evt_data[5:4];
    stat_set   = 1'b0;
    stat_clr   = 1'b0;
    stat_chan  = byte_new[CHW-1:0];
    if (evt && !evt_cd) begin
      byte_old_n = byte_new;
      byte_new_n = evt_data;
      cnt_n      = (cnt == 2'd2) ? 2'd2 : cnt + 2'd1;
      stat_clr   = 1'b1;
    end else if (evt && evt_cd) begin
      cnt_n = 2'd0;
      unique case (op)
        OP_CONNECT: if (cnt == 2'd2 && conf_ok) begin
          tbl_we           = 1'b1;
          tbl_wentry.mode  = byte_old[3:0];
          tbl_wentry.start = byte_old[4];
          tbl_wentry.tone  = byte_new[5];
          tbl_wentry.att   = evt_data[7:6];
          tbl_wentry.thr   = evt_data[5:4];
        end
        OP_TRANSP: if (cnt != 2'd0) begin
          tbl_we          = 1'b1;
          tbl_wentry.mode = MODE_TRANSP;
          tbl_wentry.att  = evt_data[7:6];
          tbl_wentry.thr  = evt_data[5:4];
        end
        OP_DISCON: if (cnt != 2'd0) begin
          tbl_we = 1'b1;
        end
        OP_MODESEL: mode_we = 1'b1;
        OP_STATUS: if (cnt != 2'd0) begin
          stat_set = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_old <= '0;
      byte_new <= '0;
      cnt      <= '0;
    end else begin
      byte_old <= byte_old_n;
      byte_new <= byte_new_n;
      cnt      <= cnt_n;
    end
  end
endmodule

// File: rtl/conf_chan_table.sv
module conf_chan_table
  import conf_port_pkg::*;
#(
  parameter int NCHAN = 32,
  localparam int CHW  = $clog2(NCHAN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] wchan,
  input  chan_entry_t    wentry,
  input  logic [CHW-1:0] rsel_a,
  output chan_entry_t    rdata_a,
  input  logic [CHW-1:0] rsel_b,
  output chan_entry_t    rdata_b
);
  chan_entry_t entries [NCHAN];

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          entries[c] <= '0;
        end else if (we && (wchan == CHW'(c))) begin
          entries[c] <= wentry;
        end
      end
    end
  endgenerate

  assign rdata_a = entries[rsel_a];
  assign rdata_b = entries[rsel_b];
endmodule

// File: rtl/conf_host_port.sv
module conf_host_port
  import conf_port_pkg::*;
#(
  parameter int NCHAN       = 32,
  parameter int NCONF       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             law_a,
  input  logic             host_cs_n,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             host_cd,
  input  logic [7:0]       bus_in,
  output logic [7:0]       bus_out,
  output logic             bus_oe,
  input  logic [NCONF-1:0] ovf_flags,
  input  logic [CHW-1:0]   tbl_sel,
  output logic [3:0]       tbl_mode,
  output logic [1:0]       tbl_att,
  output logic [1:0]       tbl_thr,
  output logic             tbl_tone,
  output logic             tbl_start,
  output logic [1:0]       fmt_bits,
  output logic             extra_bit
);
  logic           host_evt, evt_cd;
  logic [7:0]     evt_data;
  logic           tbl_we, mode_we, mode_extra, stat_set, stat_clr;
  logic [1:0]     mode_fmt;
  logic [CHW-1:0] tbl_wchan, stat_chan_d;
  chan_entry_t    tbl_wentry, sel_entry, stat_entry;

  logic           fmt_written, fmt_written_n;
  logic [1:0]     fmt_reg, fmt_reg_n;
  logic           extra_reg, extra_reg_n;
  logic           stat_on, stat_on_n;
  logic [CHW-1:0] stat_chan, stat_chan_n;
  logic [15:0]    ovf_ext;

  conf_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wr_n(host_wr_n), .cs_n(host_cs_n),
    .cd(host_cd), .din(bus_in),
    .evt(host_evt), .evt_cd(evt_cd), .evt_data(evt_data)
  );

  conf_cmd_decoder #(.NCHAN(NCHAN), .NCONF(NCONF)) u_dec (
    .clk(clk), .rst_n(rst_n), .evt(host_evt), .evt_cd(evt_cd),
    .evt_data(evt_data), .tbl_we(tbl_we), .tbl_wchan(tbl_wchan),
    .tbl_wentry(tbl_wentry), .mode_we(mode_we), .mode_extra(mode_extra),
    .mode_fmt(mode_fmt), .stat_set(stat_set), .stat_clr(stat_clr),
    .stat_chan(stat_chan_d)
  );

  conf_chan_table #(.NCHAN(NCHAN)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wchan(tbl_wchan),
    .wentry(tbl_wentry), .rsel_a(tbl_sel), .rdata_a(sel_entry),
    .rsel_b(stat_chan), .rdata_b(stat_entry)
  );

  always_comb begin
    fmt_written_n = fmt_written;
    fmt_reg_n     = fmt_reg;
    extra_reg_n   = extra_reg;
    stat_on_n     = stat_on;
    stat_chan_n   = stat_chan;
    if (mode_we) begin
      fmt_written_n = 1'b1;
      fmt_reg_n     = mode_fmt;
      extra_reg_n   = mode_extra;
    end
    if (stat_set) begin
      stat_on_n   = 1'b1;
      stat_chan_n = stat_chan_d;
    end else if (stat_clr) begin
      stat_on_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_written <= 1'b0;
      fmt_reg     <= 2'b00;
      extra_reg   <= 1'b0;
      stat_on     <= 1'b0;
      stat_chan   <= '0;
    end else begin
      fmt_written <= fmt_written_n;
      fmt_reg     <= fmt_reg_n;
      extra_reg   <= extra_reg_n;
      stat_on     <= stat_on_n;
      stat_chan   <= stat_chan_n;
    end
  end

  assign fmt_bits  = fmt_written ? fmt_reg : (law_a ? 2'b01 : 2'b11);
  assign extra_bit = extra_reg;

  always_comb begin
    ovf_ext = '0;
    ovf_ext[NCONF-1:0] = ovf_flags;
  end

  always_comb begin
    if (stat_on)      bus_out = {stat_entry.mode, stat_entry.att, stat_entry.thr};
    else if (host_cd) bus_out = ovf_ext[15:8];
    else              bus_out = ovf_ext[7:0];
  end

  assign bus_oe = rst_n & ~host_cs_n & ~host_rd_n;

  assign tbl_mode  = sel_entry.mode;
  assign tbl_att   = sel_entry.att;
  assign tbl_thr   = sel_entry.thr;
  assign tbl_tone  = sel_entry.tone;
  assign tbl_start = sel_entry.start;
endmodule

// File: rtl/conf_host_port_chk.sv
module conf_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_cs_n,
  input logic       bus_oe,
  input logic       host_evt,
  input logic       evt_cd,
  input logic [7:0] evt_data,
  input logic       tbl_we,
  input logic       stat_on,
  input logic       extra_bit,
  input logic [1:0] fmt_bits
);
  assert_bus_hiz_R9: assert property (@(posedge clk)
    host_cs_n |-> !bus_oe);

  assert_commit_on_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (host_evt && evt_cd));

  assert_status_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && !evt_cd) |=> !stat_on);

  assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && evt_cd && evt_data[3:0] == 4'b0101) |=>
      (extra_bit == $past(evt_data[6]) && fmt_bits == $past(evt_data[5:4])));

  assert_extra_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_evt && evt_cd) |=> $stable(extra_bit));
endmodule

bind conf_host_port conf_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .bus_oe(bus_oe),
  .host_evt(host_evt), .evt_cd(evt_cd), .evt_data(evt_data),
  .tbl_we(tbl_we), .stat_on(stat_on), .extra_bit(extra_bit),
  .fmt_bits(fmt_bits)
);

// File: tb/sim_conf_host_port.sv
module sim_conf_host_port;
  logic       clk = 0, rst_n = 0, law_a = 1;
  logic       cs_n = 1, rd_n = 1, wr_n = 1, cd = 0;
  logic [7:0] bus_in = 0, bus_out;
  logic       bus_oe;
  logic [9:0] ovf = 0;
  logic [4:0] sel = 0;
  logic [3:0] t_mode; logic [1:0] t_att, t_thr; logic t_tone, t_start;
  logic [1:0] fmt; logic extra;
  int checks = 0, errors = 0;
  bit busy = 1;

  int m_mode[32], m_att[32], m_thr[32], m_tone[32], m_start[32];
  int q[$];
  int m_fmt, m_extra, m_fmt_set, m_stat_on, m_stat_ch;

  always #4 clk = ~clk;

  conf_host_port u0 (
    .clk(clk), .rst_n(rst_n), .law_a(law_a), .host_cs_n(cs_n),
    .host_rd_n(rd_n), .host_wr_n(wr_n), .host_cd(cd), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ovf_flags(ovf), .tbl_sel(sel),
    .tbl_mode(t_mode), .tbl_att(t_att), .tbl_thr(t_thr), .tbl_tone(t_tone),
    .tbl_start(t_start), .fmt_bits(fmt), .extra_bit(extra)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_fmt();
    if (m_fmt_set != 0) return m_fmt;
    return law_a ? 1 : 3;
  endfunction

  function automatic int exp_read(bit c);
    if (m_stat_on != 0)
      return (m_mode[m_stat_ch] << 4) | (m_att[m_stat_ch] << 2) | m_thr[m_stat_ch];
    return c ? int'(ovf[9:8]) : int'(ovf[7:0]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_mode[i] = 0; m_att[i] = 0; m_thr[i] = 0; m_tone[i] = 0; m_start[i] = 0;
    end
    q.delete();
    m_fmt_set = 0; m_extra = 0; m_stat_on = 0; m_stat_ch = 0; m_fmt = 0;
  endtask

  task automatic set_entry(int ch, int md, int at, int th, int tn, int st);
    m_mode[ch] = md; m_att[ch] = at; m_thr[ch] = th; m_tone[ch] = tn; m_start[ch] = st;
  endtask

  task automatic model_write(bit c, int d);
    int op, n;
    if (!c) begin
      q.push_back(d);
      if (q.size() > 2) void'(q.pop_front());
      m_stat_on = 0;
      return;
    end
    op = d & 15; n = q.size();
    if (op == 7 && n == 2 && (q[0] & 15) >= 1 && (q[0] & 15) <= 10)
      set_entry(q[1] & 31, q[0] & 15, (d >> 6) & 3, (d >> 4) & 3, (q[1] >> 5) & 1, (q[0] >> 4) & 1);
    else if (op == 3 && n > 0)
      set_entry(q[n-1] & 31, 15, (d >> 6) & 3, (d >> 4) & 3, 0, 0);
    else if (op == 15 && n > 0)
      set_entry(q[n-1] & 31, 0, 0, 0, 0, 0);
    else if (op == 5) begin
      m_fmt_set = 1; m_fmt = (d >> 4) & 3; m_extra = (d >> 6) & 1;
    end else if (op == 6 && n > 0) begin
      m_stat_on = 1; m_stat_ch = q[n-1] & 31;
    end
    q.delete();
  endtask

  task automatic host_write(bit c, int d, bit csn = 0);
    @(negedge clk);
    busy = 1; bus_in = 8'(d); cd = c; cs_n = csn;
    repeat (2) @(negedge clk);
    wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (5) @(negedge clk);
    cs_n = 1;
    if (!csn) model_write(c, d);
    busy = 0;
  endtask

  task automatic host_read(bit c, string req);
    @(negedge clk);
    cd = c; cs_n = 0; rd_n = 0;
    #1;
    chk({req, " read oe"}, bus_oe, 1);
    chk({req, " read data"}, bus_out, exp_read(c));
    @(negedge clk);
    rd_n = 1; cs_n = 1;
  endtask

  task automatic probe(int ch, string req);
    @(negedge clk);
    busy = 1; sel = 5'(ch);
    #1;
    chk({req, " mode"}, t_mode, m_mode[ch]);
    chk({req, " att"}, t_att, m_att[ch]);
    chk({req, " thr"}, t_thr, m_thr[ch]);
    chk({req, " tone"}, t_tone, m_tone[ch]);
    chk({req, " start"}, t_start, m_start[ch]);
    busy = 0;
  endtask

  task automatic do_reset();
    busy = 1; rst_n = 0;
    cs_n = 0; rd_n = 0;
    #1;
    chk("R9 oe in reset", bus_oe, 0);
    repeat (3) @(negedge clk);
    cs_n = 1; rd_n = 1;
    model_reset();
    rst_n = 1;
    busy = 0;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      chk("R2/R3/R4/R10 sweep mode", t_mode, m_mode[sel]);
      chk("R2/R3/R4/R10 sweep att", t_att, m_att[sel]);
      chk("R2/R3 sweep tone", t_tone, m_tone[sel]);
      chk("R5 fmt", fmt, exp_fmt());
      chk("R5 extra", extra, m_extra);
      chk("R9 oe", bus_oe, (!cs_n && !rd_n) ? 1 : 0);
      sel <= sel + 5'd1;
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R5 default A-law fmt", fmt, 1);
    chk("R5 default extra", extra, 0);
    probe(7, "R10 reset entry");
    // R2 conference connect
    host_write(0, 8'h13); host_write(0, 8'h25); host_write(1, 8'h67);
    probe(5, "R2 connect");
    // R11 newest two bytes used
    host_write(0, 8'h1F); host_write(0, 8'h02); host_write(0, 8'h09); host_write(1, 8'h07);
    probe(9, "R11 latest bytes");
    probe(31, "R11 older byte ignored");
    // R2 conference out of range
    host_write(0, 8'h0B); host_write(0, 8'h04); host_write(1, 8'h07);
    probe(4, "R2 bad conference");
    // R3 transparent
    host_write(0, 8'h06); host_write(1, 8'hB3);
    probe(6, "R3 transparent");
    // R4 disconnect
    host_write(0, 8'h05); host_write(1, 8'h0F);
    probe(5, "R4 disconnect");
    // R6 missing data, unknown opcode
    host_write(1, 8'h07);
    host_write(0, 8'h11); host_write(0, 8'h0C); host_write(1, 8'h09); host_write(1, 8'h07);
    probe(12, "R6 unknown opcode flush");
    // R1 write with chip select high
    host_write(0, 8'h09, 1); host_write(1, 8'h0F);
    probe(9, "R1 deselected write");
    // R5 mode select
    host_write(1, 8'h65);
    chk("R5 mode fmt", fmt, 2);
    chk("R5 mode extra", extra, 1);
    // R7 overflow reads
    ovf = 10'h2A5;
    host_read(0, "R7 low");
    host_read(1, "R7 high");
    @(negedge clk); cd = 0; cs_n = 0; rd_n = 0;
    @(negedge clk); ovf = 10'h05A;
    #1 chk("R7 live", bus_out, 8'h5A);
    @(negedge clk); rd_n = 1; cs_n = 1;
    // R8 status
    host_write(0, 8'h06); host_write(1, 8'h06);
    host_read(0, "R8 status");
    host_read(1, "R8 status held");
    chk("R8 status byte", exp_read(0), 8'hFB);
    host_write(0, 8'h00);
    host_read(1, "R8 released");
    // reset with mu-law
    law_a = 0;
    do_reset();
    chk("R5 default mu-law fmt", fmt, 3);
    probe(6, "R10 table cleared");
    repeat (40) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule